// File: doc/BRIEF.md
# Temporal Property Checker

A run-time monitor that watches four single-bit inputs (`a_i`, `b_i`, `c_i`, `d_i`) on each rising clock edge and evaluates one fixed implication. The triggering part is `a` on one edge, then `b` on the edge after it. The required part starts on the edge after `b`: `c` must be high on that edge, and `d` must be high two edges after `c`. Every edge on which `a` is high opens a new attempt. Each open attempt holds its own slot, so attempts that overlap in time are judged separately.

Each attempt ends in one of three ways. It passes. It passes vacuously, when it was cut short before its triggering part completed, by the disable input or by the end-of-test input. Or it fails. Each outcome is reported as a single-cycle registered pulse. Real passes and failures also go to 16-bit saturating counters, and several verdicts that land on the same edge are all counted. The block can sit beside a design in silicon or in an emulator to flag protocol violations while the design runs.

Top module: `prop_chk_top`

## Requirements
- R1: An edge on which `a_i` is high, while `disable_i` and `eot_i` are both low, opens an attempt. If `b_i` is high on the next edge, the attempt becomes enabled. A new attempt can open on every such edge.
- R2: If `b_i` is low on the edge after the opening edge, the attempt is dropped. It produces no pulse and changes no counter.
- R3: An enabled attempt passes when `c_i` is high on the edge after `b_i` and `d_i` is high two edges after that. `pass_o` is high for the one cycle that follows the `d_i` edge.
- R4: When `c_i` or `d_i` is low on its required edge, `fail_o` is high for the one cycle that follows that edge.
- R5: At least 5 slots hold attempts, which progress independently of one another. With all four inputs held high, one pass is reported on every cycle once the pipeline has filled.
- R6: On an edge where `disable_i` is high, an attempt that is waiting for `b_i` ends with a `vac_o` pulse in the next cycle, and enabled attempts are dropped with no pulse. No attempt opens on such an edge.
- R7: On an edge where `eot_i` is high, an attempt that is waiting for `b_i` ends with a `vac_o` pulse. Enabled attempts keep being evaluated, and no attempt opens on that edge.
- R8: `pass_cnt_o` and `fail_cnt_o` each add every verdict of their kind registered on an edge, two or more when several slots finish on the same edge. They update in the same cycle as the pulses and saturate at 65535.
- R9: While `rst_ni` is low, all pulses and both counters are zero and every slot is idle.
- R10: When a slot reaches pass or fail, it is free again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples everything |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 1 | First term of the trigger |
| b_i | input | 1 | Second term of the trigger |
| c_i | input | 1 | First term of the required part |
| d_i | input | 1 | Second term of the required part |
| disable_i | input | 1 | Cancels attempts and blocks new ones |
| eot_i | input | 1 | End of test, closes attempts still waiting for the trigger |
| pass_o | output | 1 | Real pass pulse |
| vac_o | output | 1 | Vacuous pass pulse |
| fail_o | output | 1 | Failure pulse |
| pass_cnt_o | output | 16 | Saturating count of real passes |
| fail_cnt_o | output | 16 | Saturating count of failures |

## Verification
Each verdict is decided on the edge that samples its deciding input: `b` for a dropped attempt, `c` or `d` for a failure, `d` for a pass, and disable or end-of-test for a vacuous pass. It appears on the pulse outputs and the counters after that edge, with one register in between. The stimulus table therefore pairs each row's inputs with the pulses expected right after the same edge. The bench drives inputs on the falling edge and samples a quarter period after the rising edge. The counter totals are checked after the table, and saturation is checked after a long run of back-to-back overlapping passes.

// File: rtl/prop_chk_pkg.sv
package prop_chk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_EN_C,
    ST_EN_GAP,
    ST_EN_D,
    ST_PASS,
    ST_FAIL
  } slot_st_e;
endpackage

// File: rtl/prop_slot.sv
module prop_slot
  import prop_chk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  input  logic dis_i,
  input  logic eot_i,
  output logic free_o,
  output logic pass_o,
  output logic vac_o,
  output logic fail_o
);
  slot_st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    pass_o = 1'b0;
    vac_o  = 1'b0;
    fail_o = 1'b0;
    unique case (st_q)
      ST_ACT: begin
        if (dis_i || eot_i) begin
          vac_o = 1'b1;
          st_d  = ST_PASS;
        end else if (b_i) begin
          st_d = ST_EN_C;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_EN_C: begin
        if (dis_i)    st_d = ST_IDLE;
        else if (c_i) st_d = ST_EN_GAP;
        else begin
          fail_o = 1'b1;
          st_d   = ST_FAIL;
        end
      end
      ST_EN_GAP: st_d = dis_i ? ST_IDLE : ST_EN_D;
      ST_EN_D: begin
        if (dis_i) st_d = ST_IDLE;
        else if (d_i) begin
          pass_o = 1'b1;
          st_d   = ST_PASS;
        end else begin
          fail_o = 1'b1;
          st_d   = ST_FAIL;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (start_i) st_d = ST_ACT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign free_o = (st_q == ST_IDLE) || (st_q == ST_PASS) || (st_q == ST_FAIL);

  // terminal states hold one cycle only
  p_term_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PASS || st_q == ST_FAIL) |=> (st_q == ST_IDLE || st_q == ST_ACT));

  p_start_on_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> free_o);

  p_dis_no_open_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> st_q != ST_ACT);
endmodule

// File: rtl/prop_alloc.sv
module prop_alloc #(
  parameter int unsigned NSLOT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [NSLOT-1:0] free_i,
  output logic [NSLOT-1:0] gnt_o
);
  // lowest free slot wins
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (req_i && free_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  p_slot_avail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (free_i != '0));

  p_gnt_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_gnt_on_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (gnt_o != '0));
endmodule

// File: rtl/prop_sat_cnt.sv
module prop_sat_cnt #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  cnt_o
);
  localparam logic [W:0] MAX = {1'b0, {W{1'b1}}};

  logic [W-1:0] cnt_q;
  logic [W:0]   inc_ext, sum;

  always_comb begin
    inc_ext           = '0;
    inc_ext[IW-1:0]   = inc_i;
    sum               = {1'b0, cnt_q} + inc_ext;
    if (sum > MAX) sum = MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= sum[W-1:0];
  end

  assign cnt_o = cnt_q;

  p_sat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == {W{1'b1}}) |=> (cnt_q == {W{1'b1}}));

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/prop_chk_top.sv
module prop_chk_top #(
  parameter int unsigned NSLOT = 5,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             c_i,
  input  logic             d_i,
  input  logic             disable_i,
  input  logic             eot_i,
  output logic             pass_o,
  output logic             vac_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] pass_cnt_o,
  output logic [CNT_W-1:0] fail_cnt_o
);
  localparam int unsigned EW = $clog2(NSLOT + 1);

  logic             start;
  logic [NSLOT-1:0] free, gnt, pass_ev, vac_ev, fail_ev;
  logic [EW-1:0]    n_pass, n_fail;
  logic             pass_q, vac_q, fail_q;

  assign start = a_i && !disable_i && !eot_i;

  prop_alloc #(.NSLOT(NSLOT)) u_alloc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (start),
    .free_i (free),
    .gnt_o  (gnt)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    prop_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (gnt[g]),
      .b_i     (b_i),
      .c_i     (c_i),
      .d_i     (d_i),
      .dis_i   (disable_i),
      .eot_i   (eot_i),
      .free_o  (free[g]),
      .pass_o  (pass_ev[g]),
      .vac_o   (vac_ev[g]),
      .fail_o  (fail_ev[g])
    );
  end

  always_comb begin
    n_pass = '0;
    n_fail = '0;
    for (int i = 0; i < NSLOT; i++) begin
      n_pass = n_pass + EW'(pass_ev[i]);
      n_fail = n_fail + EW'(fail_ev[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q <= 1'b0;
      vac_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      pass_q <= |pass_ev;
      vac_q  <= |vac_ev;
      fail_q <= |fail_ev;
    end
  end

  prop_sat_cnt #(.W(CNT_W), .IW(EW)) u_pass_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (n_pass),
    .cnt_o  (pass_cnt_o)
  );

  prop_sat_cnt #(.W(CNT_W), .IW(EW)) u_fail_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (n_fail),
    .cnt_o  (fail_cnt_o)
  );

  assign pass_o = pass_q;
  assign vac_o  = vac_q;
  assign fail_o = fail_q;

  p_dis_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> (!pass_o && !fail_o));

  p_vac_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vac_o |-> $past(disable_i || eot_i));

  p_fail_counted_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (fail_cnt_o != '0));

  p_pass_counted_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (pass_cnt_o != '0));
endmodule

// File: tb/prop_chk_top_test.sv
module prop_chk_top_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic a = 0, b = 0, c = 0, d = 0, dis = 0, eot = 0;
  logic pass_o, vac_o, fail_o;
  logic [15:0] pass_cnt, fail_cnt;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prop_chk_top uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .a_i        (a),
    .b_i        (b),
    .c_i        (c),
    .d_i        (d),
    .disable_i  (dis),
    .eot_i      (eot),
    .pass_o     (pass_o),
    .vac_o      (vac_o),
    .fail_o     (fail_o),
    .pass_cnt_o (pass_cnt),
    .fail_cnt_o (fail_cnt)
  );

  // {a,b,c,d,dis,eot, exp pass,vac,fail} ; expected right after the same edge
  localparam int NV = 58;
  localparam logic [8:0] VEC [0:NV-1] = '{
    9'b100000_000, 9'b010000_000, 9'b001000_000, 9'b000000_000, // R3 pass
    9'b000100_100, 9'b000000_000,
    9'b100000_000, 9'b000000_000, 9'b000000_000,               // R2 no b
    9'b100000_000, 9'b010000_000, 9'b000000_001, 9'b000000_000, // R4 c low
    9'b100000_000, 9'b010000_000, 9'b001000_000, 9'b000000_000, // R4 d low
    9'b000000_001,
    9'b100000_000, 9'b110000_000, 9'b011000_000, 9'b001000_000, // R5 overlap
    9'b000100_100, 9'b000000_001,
    9'b100000_000, 9'b010000_000, 9'b101000_000, 9'b010000_000, // R8 pass+fail same edge
    9'b000100_101, 9'b000000_000,
    9'b100000_000, 9'b010000_000, 9'b101000_000, 9'b010000_000, // R8 two fails same edge
    9'b000000_001, 9'b000000_000,
    9'b100000_000, 9'b010010_010, 9'b000000_000,               // R6 vacuous
    9'b100000_000, 9'b010000_000, 9'b001010_000, 9'b000000_000, // R6 enabled dropped
    9'b000100_000,
    9'b100010_000, 9'b010000_000, 9'b001000_000, 9'b000000_000, // R6 no open
    9'b000100_000,
    9'b100000_000, 9'b010001_010, 9'b000000_000,               // R7 vacuous
    9'b100000_000, 9'b010000_000, 9'b001001_000, 9'b000000_000, // R7 enabled continues
    9'b000100_100, 9'b000000_000
  };

  function automatic string row_req(input int r);
    if (r < 6)       return "R3";
    else if (r < 9)  return "R2";
    else if (r < 18) return "R4";
    else if (r < 24) return "R5";
    else if (r < 36) return "R8";
    else if (r < 49) return "R6";
    else             return "R7";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(150000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (2) @(posedge clk);
    #5;
    check("R9 pulses", {29'd0, pass_o, vac_o, fail_o}, 32'd0);
    check("R9 counters", {pass_cnt, fail_cnt}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      {a, b, c, d, dis, eot} = VEC[r][8:3];
      @(posedge clk);
      #5;
      check(row_req(r), {29'd0, pass_o, vac_o, fail_o}, {29'd0, VEC[r][2:0]});
    end
    @(negedge clk);
    {a, b, c, d, dis, eot} = '0;
    @(posedge clk);
    #5;
    check("R8 pass total", {16'd0, pass_cnt}, 32'd4);
    check("R8 fail total", {16'd0, fail_cnt}, 32'd6);
    check("R10 idle after", {29'd0, pass_o, vac_o, fail_o}, 32'd0);

    // R9 reset mid-run clears counters
    @(negedge clk);
    rst_ni = 1'b0;
    #5;
    check("R9 async clear", {pass_cnt, fail_cnt}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R5 / R10 / R8: all inputs high, one pass per cycle, counter saturates
    @(negedge clk);
    {a, b, c, d} = 4'b1111;
    for (int k = 0; k < 8; k++) @(posedge clk);
    #5;
    check("R5 pass count after 8 edges", {16'd0, pass_cnt}, 32'd4);
    check("R5 pass pulse", {31'd0, pass_o}, 32'd1);
    for (int k = 0; k < 65600; k++) @(posedge clk);
    #5;
    check("R8 saturated", {16'd0, pass_cnt}, 32'd65535);
    check("R8 no fails", {16'd0, fail_cnt}, 32'd0);
    check("R5 still passing", {31'd0, pass_o}, 32'd1);
    @(negedge clk);
    {a, b, c, d} = 4'b0000;
    repeat (6) @(posedge clk);
    #5;
    check("R8 held at max", {16'd0, pass_cnt}, 32'd65535);
    check("R1 quiet when a low", {29'd0, pass_o, vac_o, fail_o}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule